// File: doc/BRIEF.md
# Programmable Video Sync Generator

This block turns a single pixel clock into the raster timing of a television or monitor. It produces horizontal sync and blank, vertical sync and blank, and it can fold these into a composite sync and a composite blank. Every pulse edge, the line length and the field length are held in writable registers, so line rate and field rate follow only from those register values and the clock frequency. A status register selects interlaced or progressive scanning, separate or composite outputs, and equalizing and serration shaping of the composite sync. It also holds a run bit that freezes the whole raster while software reprograms it.

A synchronous write port (address, data, strobe) loads the registers. A synchronous clear input, or the asynchronous reset, reloads standard-definition defaults. These defaults give a 910-clock line and a 262-line field, which suit a 14.31818 MHz clock. A parameter chooses whether the run bit comes up set or cleared after clear. When it comes up set, a single clear pulse starts the block straight into the default timing. In composite mode four extra outputs become active: a horizontal gate, a vertical gate, a cursor-position strobe and a vertical interrupt.

Top module: `vsync_gen_top`

## Requirements
- R1: Reset and a synchronous `i_clear` load these defaults and zero the counters. Status is 0x0007 plus bit 10 = `CLKEN_RESET`. Line length is 910. Hblank is [0,150) and hsync is [20,87). Field length is 262. Vblank is [0,20) and vsync is [3,6). The equalizing window is [0,9). The equalizing width is 33 and the serration width is 67. The cursor is at column 455, line 100.
- R2: Status bit 10 is the run bit. While it is 0, the counters hold and every output stays constant.
- R3: The column counter runs 0 to L-1, where L is the line length (address 1). The line counter advances when the column counter wraps. `o_hblank` (separate mode) is high for columns in [addr2, addr3). The internal hsync is high for columns in [addr4, addr5).
- R4: The line counter wraps after F-1, where F is the field length (address 6). `o_vblank` is high for lines in [addr7, addr8). `o_vsync` is high from (line addr9, column X) up to but not including (line addr10, column X). X is 0, except in the second field of interlaced mode, where X = L/2. The field flag toggles at each wrap when status bit 0 is 1, and is 0 otherwise.
- R5: With status bit 1 (composite) set, `o_hsync` carries the composite sync and `o_hblank` carries hblank OR vblank.
- R6: With status bits 1 and 2 set, composite sync behaves as follows. During vsync it is high except for serration gaps: the S columns ending at L/2 and the last S columns of the line, where S is at address 14. On lines in [addr11, addr12) outside vsync, it is high for columns in [0,E) and [L/2, L/2+E), where E is at address 13. Elsewhere it equals hsync.
- R7: With status bit 1 set and bit 2 clear, composite sync is hsync XOR vsync.
- R8: In composite mode `o_hgate` = NOT hblank and `o_vgate` = NOT vblank. `o_cursor` is high at the column and line held at addresses 15 and 16. `o_vint` is high at column 0 of line addr7. In separate mode all four are 0.
- R9: A write lands in the addressed register at the clock edge and takes effect from the next cycle. Writes to addresses 17 and above change nothing.
- R10: A counter wraps whenever its value is at or above its limit minus one, so shortening the line or field length past the current position wraps it on the next running edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_clear | input | 1 | Synchronous reload of defaults |
| i_wr | input | 1 | Register write strobe |
| i_addr | input | ADDR_W | Register address |
| i_wdata | input | DATA_W | Register write data |
| o_hsync | output | 1 | Horizontal sync, or composite sync in composite mode |
| o_vsync | output | 1 | Vertical sync |
| o_hblank | output | 1 | Horizontal blank, or composite blank in composite mode |
| o_vblank | output | 1 | Vertical blank |
| o_hgate | output | 1 | Horizontal active gate (composite mode) |
| o_vgate | output | 1 | Vertical active gate (composite mode) |
| o_cursor | output | 1 | Cursor position strobe (composite mode) |
| o_vint | output | 1 | Vertical interrupt strobe (composite mode) |

## Verification
The bench builds the block with `CLKEN_RESET` = 0 and the other parameters at their defaults. After reset the raster is therefore frozen, so the reset state and the hold behaviour can be observed before any write. The default timing is then started and followed through its equalizing lines and into the serrated vsync. Short random line and field lengths then bring many field wraps, both interlaced fields and every status combination within a short run. Directed writes cover shrinking the line length under a running counter and writes to unused addresses.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

   localparam int REG_STATUS  = 0;
   localparam int REG_LINELEN = 1;
   localparam int REG_HB_ON   = 2;
   localparam int REG_HB_OFF  = 3;
   localparam int REG_HS_ON   = 4;
   localparam int REG_HS_OFF  = 5;
   localparam int REG_FLDLEN  = 6;
   localparam int REG_VB_ON   = 7;
   localparam int REG_VB_OFF  = 8;
   localparam int REG_VS_ON   = 9;
   localparam int REG_VS_OFF  = 10;
   localparam int REG_EQ_FROM = 11;
   localparam int REG_EQ_TO   = 12;
   localparam int REG_EQ_WID  = 13;
   localparam int REG_SER_WID = 14;
   localparam int REG_CUR_COL = 15;
   localparam int REG_CUR_LIN = 16;
   localparam int NUM_REGS    = 17;

   localparam int ST_INTERLACE = 0;
   localparam int ST_COMPOSITE = 1;
   localparam int ST_EQUALIZE  = 2;
   localparam int ST_RUN       = 10;

   typedef struct packed {
      logic hsync;
      logic vsync;
      logic hblank;
      logic vblank;
      logic hgate;
      logic vgate;
      logic cursor;
      logic vint;
   } vsg_pins_t;

   function automatic logic [15:0] dflt(input int idx);
      case (idx)
         REG_STATUS:  dflt = 16'h0007;
         REG_LINELEN: dflt = 16'd910;
         REG_HB_ON:   dflt = 16'd0;
         REG_HB_OFF:  dflt = 16'd150;
         REG_HS_ON:   dflt = 16'd20;
         REG_HS_OFF:  dflt = 16'd87;
         REG_FLDLEN:  dflt = 16'd262;
         REG_VB_ON:   dflt = 16'd0;
         REG_VB_OFF:  dflt = 16'd20;
         REG_VS_ON:   dflt = 16'd3;
         REG_VS_OFF:  dflt = 16'd6;
         REG_EQ_FROM: dflt = 16'd0;
         REG_EQ_TO:   dflt = 16'd9;
         REG_EQ_WID:  dflt = 16'd33;
         REG_SER_WID: dflt = 16'd67;
         REG_CUR_COL: dflt = 16'd455;
         REG_CUR_LIN: dflt = 16'd100;
         default:     dflt = 16'd0;
      endcase
   endfunction

endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
   import vsg_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 5,
   parameter bit CLKEN_RESET = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               clear,
   input  logic                               wr,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [DATA_W-1:0]                  wdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0]    regs
);

   localparam logic [DATA_W-1:0] RUN_MASK = DATA_W'(1) << ST_RUN;

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [DATA_W-1:0] BASE_VAL = DATA_W'(dflt(gi));
      logic [DATA_W-1:0] rst_val;
      if (gi == REG_STATUS && CLKEN_RESET) begin : g_run_on
         assign rst_val = BASE_VAL | RUN_MASK;
      end else begin : g_run_off
         assign rst_val = BASE_VAL;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[gi] <= rst_val;
         end else if (clear) begin
            regs[gi] <= rst_val;
         end else if (wr && addr == ADDR_W'(gi)) begin
            regs[gi] <= wdata;
         end
      end
   end

   AST_CLEAR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (regs[REG_STATUS][ST_RUN] == CLKEN_RESET) &&
                (regs[REG_LINELEN] == DATA_W'(dflt(REG_LINELEN))) &&
                (regs[REG_FLDLEN] == DATA_W'(dflt(REG_FLDLEN)))); // R1

   AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clear && int'(addr) >= NUM_REGS) |=> $stable(regs)); // R9

endmodule

// File: rtl/vsg_timebase.sv
module vsg_timebase #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic             interlace,
   input  logic [CNT_W-1:0] line_len,
   input  logic [CNT_W-1:0] field_len,
   output logic [CNT_W-1:0] col,
   output logic [CNT_W-1:0] lin,
   output logic             field
);

   localparam int EXT_W = CNT_W + 1;

   logic last_col;
   logic last_lin;

   assign last_col = (EXT_W'(col) + EXT_W'(1)) >= EXT_W'(line_len);
   assign last_lin = (EXT_W'(lin) + EXT_W'(1)) >= EXT_W'(field_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col   <= '0;
         lin   <= '0;
         field <= 1'b0;
      end else if (clear) begin
         col   <= '0;
         lin   <= '0;
         field <= 1'b0;
      end else if (run) begin
         if (last_col) begin
            col <= '0;
            if (last_lin) begin
               lin   <= '0;
               field <= interlace ? ~field : 1'b0;
            end else begin
               lin <= lin + 1'b1;
            end
         end else begin
            col <= col + 1'b1;
         end
      end
   end

   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> ($stable(col) && $stable(lin) && $stable(field))); // R2

   AST_LINE_HOLDS_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear && (EXT_W'(col) + EXT_W'(1)) < EXT_W'(line_len))
      |=> ($stable(lin) && $stable(field) && col == $past(col) + 1'b1)); // R3

   AST_PROGRESSIVE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!interlace && !field) |=> !field); // R4

endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
   import vsg_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic             interlace,
   input  logic             composite,
   input  logic             equalize,
   input  logic [CNT_W-1:0] col,
   input  logic [CNT_W-1:0] lin,
   input  logic             field,
   input  logic [CNT_W-1:0] line_len,
   input  logic [CNT_W-1:0] hb_on,
   input  logic [CNT_W-1:0] hb_off,
   input  logic [CNT_W-1:0] hs_on,
   input  logic [CNT_W-1:0] hs_off,
   input  logic [CNT_W-1:0] vb_on,
   input  logic [CNT_W-1:0] vb_off,
   input  logic [CNT_W-1:0] vs_on,
   input  logic [CNT_W-1:0] vs_off,
   input  logic [CNT_W-1:0] eq_from,
   input  logic [CNT_W-1:0] eq_to,
   input  logic [CNT_W-1:0] eq_wid,
   input  logic [CNT_W-1:0] ser_wid,
   input  logic [CNT_W-1:0] cur_col,
   input  logic [CNT_W-1:0] cur_lin,
   output vsg_pins_t        pins
);

   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] half;
   logic [CNT_W-1:0] vs_col;
   logic             hs_i, hb_i, vb_i, vs_i;
   logic             eq_line, in_serr, eq_pulse;
   logic             csync;
   logic [EXT_W-1:0] col_x, col_plus_ser;

   assign half         = line_len >> 1;
   assign vs_col       = (interlace && field) ? half : '0;
   assign col_x        = EXT_W'(col);
   assign col_plus_ser = col_x + EXT_W'(ser_wid);

   assign hs_i = (col >= hs_on) && (col < hs_off);
   assign hb_i = (col >= hb_on) && (col < hb_off);
   assign vb_i = (lin >= vb_on) && (lin < vb_off);
   assign vs_i = ((lin > vs_on) || (lin == vs_on && col >= vs_col)) &&
                 ((lin < vs_off) || (lin == vs_off && col < vs_col));

   assign eq_line  = (lin >= eq_from) && (lin < eq_to);
   assign in_serr  = ((col_plus_ser >= EXT_W'(half)) && (col < half)) ||
                     (col_plus_ser >= EXT_W'(line_len));
   assign eq_pulse = (col < eq_wid) ||
                     ((col >= half) && (col_x < EXT_W'(half) + EXT_W'(eq_wid)));

   always_comb begin
      if (!equalize) begin
         csync = hs_i ^ vs_i;
      end else if (vs_i) begin
         csync = ~in_serr;
      end else if (eq_line) begin
         csync = eq_pulse;
      end else begin
         csync = hs_i;
      end
   end

   always_comb begin
      pins.vsync  = vs_i;
      pins.vblank = vb_i;
      if (composite) begin
         pins.hsync  = csync;
         pins.hblank = hb_i | vb_i;
         pins.hgate  = ~hb_i;
         pins.vgate  = ~vb_i;
         pins.cursor = (col == cur_col) && (lin == cur_lin);
         pins.vint   = (lin == vb_on) && (col == '0);
      end else begin
         pins.hsync  = hs_i;
         pins.hblank = hb_i;
         pins.hgate  = 1'b0;
         pins.vgate  = 1'b0;
         pins.cursor = 1'b0;
         pins.vint   = 1'b0;
      end
   end

   AST_VINT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pins.vint && run && !clear && line_len > CNT_W'(1)) |=> !pins.vint); // R8

endmodule

// File: rtl/vsync_gen_top.sv
module vsync_gen_top
   import vsg_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 5,
   parameter bit CLKEN_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_clear,
   input  logic              i_wr,
   input  logic [ADDR_W-1:0] i_addr,
   input  logic [DATA_W-1:0] i_wdata,
   output logic              o_hsync,
   output logic              o_vsync,
   output logic              o_hblank,
   output logic              o_vblank,
   output logic              o_hgate,
   output logic              o_vgate,
   output logic              o_cursor,
   output logic              o_vint
);

   if (DATA_W <= ST_RUN) begin : g_chk_data
      $error("DATA_W must hold the run bit");
   end
   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("CNT_W must not exceed DATA_W");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_chk_addr
      $error("ADDR_W too narrow for the register bank");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic [NUM_REGS-1:0][CNT_W-1:0]  tv;
   logic [CNT_W-1:0]                col, lin;
   logic                            field;
   logic                            run, interlace, composite, equalize;
   vsg_pins_t                       pins;
   logic                            unused_bits;

   vsg_regs #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .CLKEN_RESET (CLKEN_RESET)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (i_clear),
      .wr    (i_wr),
      .addr  (i_addr),
      .wdata (i_wdata),
      .regs  (regs)
   );

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_slice
      assign tv[gi] = regs[gi][CNT_W-1:0];
   end

   always_comb begin
      unused_bits = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
         unused_bits = unused_bits ^ (^regs[i]);
      end
   end

   assign run       = regs[REG_STATUS][ST_RUN];
   assign interlace = regs[REG_STATUS][ST_INTERLACE];
   assign composite = regs[REG_STATUS][ST_COMPOSITE];
   assign equalize  = regs[REG_STATUS][ST_EQUALIZE];

   vsg_timebase #(.CNT_W(CNT_W)) u_timebase (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (i_clear),
      .run       (run),
      .interlace (interlace),
      .line_len  (tv[REG_LINELEN]),
      .field_len (tv[REG_FLDLEN]),
      .col       (col),
      .lin       (lin),
      .field     (field)
   );

   vsg_decode #(.CNT_W(CNT_W)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (i_clear),
      .run       (run),
      .interlace (interlace),
      .composite (composite),
      .equalize  (equalize),
      .col       (col),
      .lin       (lin),
      .field     (field),
      .line_len  (tv[REG_LINELEN]),
      .hb_on     (tv[REG_HB_ON]),
      .hb_off    (tv[REG_HB_OFF]),
      .hs_on     (tv[REG_HS_ON]),
      .hs_off    (tv[REG_HS_OFF]),
      .vb_on     (tv[REG_VB_ON]),
      .vb_off    (tv[REG_VB_OFF]),
      .vs_on     (tv[REG_VS_ON]),
      .vs_off    (tv[REG_VS_OFF]),
      .eq_from   (tv[REG_EQ_FROM]),
      .eq_to     (tv[REG_EQ_TO]),
      .eq_wid    (tv[REG_EQ_WID]),
      .ser_wid   (tv[REG_SER_WID]),
      .cur_col   (tv[REG_CUR_COL]),
      .cur_lin   (tv[REG_CUR_LIN]),
      .pins      (pins)
   );

   assign o_hsync  = pins.hsync;
   assign o_vsync  = pins.vsync;
   assign o_hblank = pins.hblank;
   assign o_vblank = pins.vblank;
   assign o_hgate  = pins.hgate;
   assign o_vgate  = pins.vgate;
   assign o_cursor = pins.cursor;
   assign o_vint   = pins.vint;

endmodule

// File: tb/vsync_gen_top_tb.sv
module vsync_gen_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 5;
   localparam int DATA_W     = 16;
   localparam int NREG       = 17;
   localparam int MAX_CYCLES = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              i_clear = 1'b0;
   logic              i_wr = 1'b0;
   logic [ADDR_W-1:0] i_addr = '0;
   logic [DATA_W-1:0] i_wdata = '0;
   logic o_hsync, o_vsync, o_hblank, o_vblank, o_hgate, o_vgate, o_cursor, o_vint;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   int m_reg [NREG];
   int m_h, m_v, m_f;

   always #(CLK_PERIOD/2) clk = ~clk;

   vsync_gen_top #(
      .CNT_W(12), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLKEN_RESET(1'b0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .i_clear(i_clear), .i_wr(i_wr),
      .i_addr(i_addr), .i_wdata(i_wdata),
      .o_hsync(o_hsync), .o_vsync(o_vsync), .o_hblank(o_hblank), .o_vblank(o_vblank),
      .o_hgate(o_hgate), .o_vgate(o_vgate), .o_cursor(o_cursor), .o_vint(o_vint)
   );

   // R1 default values (run bit cleared: CLKEN_RESET = 0)
   function automatic void model_defaults();
      m_reg = '{7, 910, 0, 150, 20, 87, 262, 0, 20, 3, 6, 0, 9, 33, 67, 455, 100};
      m_h = 0; m_v = 0; m_f = 0;
   endfunction

   function automatic int rv(int i);
      return m_reg[i] & 'hFFF;
   endfunction

   // R2, R3, R4, R9, R10 next-state rules
   function automatic void model_step(bit w, int a, int d, bit c);
      if (c) begin
         model_defaults();
         return;
      end
      if (((m_reg[0] >> 10) & 1) == 1) begin
         if (m_h + 1 >= rv(1)) begin
            m_h = 0;
            if (m_v + 1 >= rv(6)) begin
               m_v = 0;
               m_f = ((m_reg[0] & 1) == 1) ? (1 - m_f) : 0;
            end else begin
               m_v = m_v + 1;
            end
         end else begin
            m_h = m_h + 1;
         end
      end
      if (w && a < NREG) m_reg[a] = d & 'hFFFF;
   endfunction

   function automatic logic [7:0] model_out();
      int  half, xo;
      bit  intl, comp, eq, hs, hb, vb, vs, cs, serr, eqp;
      intl = (m_reg[0] & 1) != 0;
      comp = (m_reg[0] & 2) != 0;
      eq   = (m_reg[0] & 4) != 0;
      half = rv(1) / 2;
      xo   = (intl && m_f == 1) ? half : 0;
      hs = (m_h >= rv(4)) && (m_h < rv(5));
      hb = (m_h >= rv(2)) && (m_h < rv(3));
      vb = (m_v >= rv(7)) && (m_v < rv(8));
      vs = ((m_v > rv(9)) || (m_v == rv(9) && m_h >= xo)) &&
           ((m_v < rv(10)) || (m_v == rv(10) && m_h < xo));
      serr = ((m_h + rv(14) >= half) && (m_h < half)) || (m_h + rv(14) >= rv(1));
      eqp  = (m_h < rv(13)) || ((m_h >= half) && (m_h < half + rv(13)));
      if (!eq) cs = hs ^ vs;
      else if (vs) cs = !serr;
      else if (m_v >= rv(11) && m_v < rv(12)) cs = eqp;
      else cs = hs;
      if (comp)
         return {cs, vs, hb | vb, vb, !hb, !vb,
                 (m_h == rv(15)) && (m_v == rv(16)), (m_v == rv(7)) && (m_h == 0)};
      return {hs, vs, hb, vb, 4'b0000};
   endfunction

   function automatic logic [7:0] dut_out();
      return {o_hsync, o_vsync, o_hblank, o_vblank, o_hgate, o_vgate, o_cursor, o_vint};
   endfunction

   task automatic check_all(string note);
      logic [7:0] e, g;
      string tags [8];
      string names [8];
      bit comp, eq;
      comp = (m_reg[0] & 2) != 0;
      eq   = (m_reg[0] & 4) != 0;
      names = '{"o_hsync", "o_vsync", "o_hblank", "o_vblank",
                "o_hgate", "o_vgate", "o_cursor", "o_vint"};
      tags[0] = !comp ? "R3" : (eq ? "R6" : "R7");
      tags[1] = "R4";
      tags[2] = comp ? "R5" : "R3";
      tags[3] = "R4";
      for (int k = 4; k < 8; k++) tags[k] = "R8";
      e = model_out();
      g = dut_out();
      for (int k = 0; k < 8; k++) begin
         n_checks++;
         if (e[7-k] !== g[7-k]) begin
            n_fails++;
            $display("FAIL %s %s (%s) h=%0d v=%0d f=%0d got %b expected %b",
                     tags[k], names[k], note, m_h, m_v, m_f, g[7-k], e[7-k]);
         end
      end
   endtask

   task automatic tick(bit w, int a, int d, bit c, string note);
      i_wr    = w;
      i_addr  = ADDR_W'(a);
      i_wdata = DATA_W'(d);
      i_clear = c;
      @(posedge clk);
      model_step(w, a, d, c);
      @(negedge clk);
      i_wr    = 1'b0;
      i_clear = 1'b0;
      check_all(note);
   endtask

   task automatic run_cycles(int n, string note);
      for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 1'b0, note);
   endtask

   initial begin : watchdog
      repeat (MAX_CYCLES) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog expired got running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] held;
      int ht, vt, st;
      void'($urandom(32'd715));
      model_defaults();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1 reset state");

      // R2: run bit 0 after reset, raster frozen
      held = dut_out();
      for (int i = 0; i < 40; i++) begin
         tick(1'b0, 0, 0, 1'b0, "R2 frozen after reset");
         n_checks++;
         if (dut_out() !== held) begin
            n_fails++;
            $display("FAIL R2 frozen outputs got %b expected %b", dut_out(), held);
         end
      end

      // R1/R6: start default timing, through equalizing lines into serrated vsync
      tick(1'b1, 0, 'h0407, 1'b0, "R9 enable write");
      run_cycles(4200, "R1 default timing");

      // R2: stop mid-line and hold
      tick(1'b1, 0, 'h0007, 1'b0, "R2 stop");
      held = dut_out();
      for (int i = 0; i < 30; i++) begin
         tick(1'b0, 0, 0, 1'b0, "R2 hold");
         n_checks++;
         if (dut_out() !== held) begin
            n_fails++;
            $display("FAIL R2 held outputs got %b expected %b", dut_out(), held);
         end
      end

      // R1: clear mid-run restores defaults
      tick(1'b1, 0, 'h0407, 1'b0, "R9 restart");
      run_cycles(100, "R3 running");
      tick(1'b0, 0, 0, 1'b1, "R1 clear");
      run_cycles(20, "R1 after clear");

      // R10: shrink line length under a running counter
      tick(1'b1, 0, 'h0400, 1'b0, "R10 separate mode");
      tick(1'b1, 1, 30, 1'b0, "R10 setup");
      tick(1'b1, 2, 0, 1'b0, "R10 setup");
      tick(1'b1, 3, 1, 1'b0, "R10 setup");
      while (m_h != 25) tick(1'b0, 0, 0, 1'b0, "R10 advance");
      tick(1'b1, 1, 10, 1'b0, "R10 shrink");
      tick(1'b0, 0, 0, 1'b0, "R10 wrap");
      n_checks++;
      if (o_hblank !== 1'b1) begin
         n_fails++;
         $display("FAIL R10 hblank after wrap got %b expected 1", o_hblank);
      end

      // R9: writes to unused addresses change nothing
      for (int i = 0; i < 20; i++)
         tick(1'b1, 17 + ($urandom % 15), $urandom, 1'b0, "R9 ignored address");

      // random configurations
      for (int cfg = 0; cfg < 10; cfg++) begin
         ht = 12 + $urandom % 28;
         vt = 5 + $urandom % 9;
         st = 'h0400 | ($urandom % 8);
         if (cfg < 4) st = 'h0400 | (cfg == 0 ? 'h7 : cfg == 1 ? 'h3 : cfg == 2 ? 'h6 : 'h1);
         tick(1'b1, 1, ht, 1'b0, "R9 line length");
         tick(1'b1, 6, vt, 1'b0, "R9 field length");
         for (int r = 2; r < NREG; r++) begin
            if (r == 6) continue;
            if (r >= 6 && r <= 12) tick(1'b1, r, $urandom % (vt + 1), 1'b0, "R9 vertical");
            else if (r == 15) tick(1'b1, r, $urandom % ht, 1'b0, "R9 cursor");
            else if (r == 16) tick(1'b1, r, $urandom % vt, 1'b0, "R9 cursor");
            else tick(1'b1, r, $urandom % (ht + 1), 1'b0, "R9 horizontal");
         end
         tick(1'b1, 0, st, 1'b0, "R9 status");
         run_cycles(ht * vt * 3, "R4 random frames");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule